// File: doc/BRIEF.md
# Burst-Refill Byte Stream Buffer

This block keeps a byte-wide output stream supplied from a memory source that only delivers data in bursts. A ring of storage sits between the two sides. A write pointer and a read pointer address the ring, and one occupancy register tracks how many entries it holds. Everything runs on one clock. A downstream consumer takes one byte per accepted ready/valid handshake. The memory side writes a burst of consecutive words, one per cycle, once it has acknowledged a request.

The refill controller compares the committed fill level against a low-water mark. The committed level is the stored entries plus the words already requested but not yet received. When that level falls below the mark and no burst is outstanding, the controller raises a request. The request holds until the memory side acknowledges it. The burst length is reserved at the moment the request is issued, so the burst always fits, however long the memory takes to answer.

Depth, burst length, low-water mark and data width are parameters. An elaboration check rejects any setting in which the mark plus one burst exceeds the depth. A write into a full ring and a read from an empty one each raise a one-cycle error pulse.

Top module: `refill_stream_buf`

## Requirements
- R1: While `rst` is high, `level`, `out_valid`, `mem_req`, `ovf_err` and `unf_err` are all 0. On the first rising edge after `rst` falls, `mem_req` goes to 1, because an empty ring is below the mark.
- R2: Bytes leave on `out_data` in the order they were accepted from `mem_wdata`. `out_data` holds the oldest stored byte whenever `out_valid` is 1.
- R3: `level` counts accepted writes minus accepted reads and changes on the edge that accepts them. `out_valid` is 1 exactly when `level` is nonzero. `level` never exceeds DEPTH.
- R4: A request is issued only when no burst words are outstanding and `level` plus outstanding words is below LOW_MARK. `mem_req` stays 0 from the acknowledge until the last burst word has been written. It also stays 0 while the committed level is at or above LOW_MARK.
- R5: Once raised, `mem_req` holds until an edge at which `mem_ack` is 1. It is 0 after that edge.
- R6: If the committed level is below LOW_MARK after the edge that writes the last word of a burst, `mem_req` rises on the next edge.
- R7: A write offered (`mem_wvalid`=1) while `level` equals DEPTH is dropped, even if a read is accepted on the same edge. `ovf_err` is 1 for the one cycle after that edge.
- R8: `out_ready`=1 while `level` is 0 changes nothing. `unf_err` is 1 for the one cycle after that edge.
- R9: An edge that accepts one write and one read leaves `level` unchanged, and the byte order stays intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Burst request toward memory, held until acknowledged |
| mem_ack | input | 1 | Memory accepted the request |
| mem_wvalid | input | 1 | Burst word present on mem_wdata |
| mem_wdata | input | W | Burst word |
| out_valid | output | 1 | A byte is available |
| out_ready | input | 1 | Consumer takes the byte this cycle |
| out_data | output | W | Oldest stored byte |
| level | output | $clog2(DEPTH+1) | Current occupancy |
| ovf_err | output | 1 | Pulse: write dropped at full |
| unf_err | output | 1 | Pulse: read attempted at empty |

## Verification
The bench varies the acknowledge delay and the latency to the first word from burst to burst. It checks that no second request appears during the latency window. A controller that ignored the outstanding words would request again there and overcommit the ring. The bench overlaps a burst with a continuous drain, which would expose a counter that mishandles simultaneous write and read. It fills the ring to DEPTH and then offers a write together with a read. A design that let that write through would overwrite unread data or count past DEPTH. It reads from the empty ring, and a wrong design would move the read pointer and corrupt later output.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // Returns 1 when one burst of headroom remains above the low-water mark.
  function automatic bit cfg_has_headroom(input int depth, input int burst, input int low_mark);
    return (low_mark + burst) <= depth;
  endfunction
endpackage

// File: rtl/rf_ring_store.sv
module rf_ring_store #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  // Asynchronous read: distributed RAM, the oldest byte is visible at once.
  assign rdata = cells[raddr];
endmodule

// File: rtl/rf_ptr_track.sv
module rf_ptr_track #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_try,
  input  logic          rd_try,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          unf
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic is_full, is_empty;
  assign is_full  = (count == FULL);
  assign is_empty = (count == '0);
  assign wr_fire  = wr_try && !is_full;
  assign rd_fire  = rd_try && !is_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      if (wr_fire) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_fire) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({wr_fire, rd_fire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      ovf <= wr_try && is_full;
      unf <= rd_try && is_empty;
    end
  end

  AST_PTRS_MEET_AT_EDGES: assert property (@(posedge clk) disable iff (rst)
    (count == '0 || count == FULL) |-> (wr_ptr == rd_ptr)); // R3

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= FULL); // R3
endmodule

// File: rtl/rf_refill_ctl.sv
module rf_refill_ctl #(
  parameter int DEPTH    = 16,
  parameter int BURST    = 4,
  parameter int LOW_MARK = 8,
  parameter int CW       = $clog2(DEPTH + 1),
  parameter int PW       = $clog2(BURST + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] level,
  input  logic          wr_fire,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic [PW-1:0] pending
);
  localparam int SW = CW + 1;

  logic [SW-1:0] committed;
  logic          issue;

  assign committed = SW'(level) + SW'(pending);
  assign issue     = !mem_req && (pending == '0) && (committed < SW'(LOW_MARK));

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req <= 1'b0;
      pending <= '0;
    end else begin
      if (issue)        mem_req <= 1'b1;
      else if (mem_ack) mem_req <= 1'b0;

      if (issue)                        pending <= PW'(BURST);
      else if (wr_fire && pending != '0) pending <= pending - 1'b1;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req); // R5

  AST_ONE_BURST: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> ($past(pending) == '0)); // R4

  AST_NO_OVERCOMMIT: assert property (@(posedge clk) disable iff (rst)
    committed <= SW'(DEPTH)); // R4
endmodule

// File: rtl/refill_stream_buf.sv
module refill_stream_buf #(
  parameter int W        = 8,
  parameter int DEPTH    = 16,
  parameter int BURST    = 4,
  parameter int LOW_MARK = 8,
  parameter int AW       = $clog2(DEPTH),
  parameter int CW       = $clog2(DEPTH + 1),
  parameter int PW       = $clog2(BURST + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_req,
  input  logic          mem_ack,
  input  logic          mem_wvalid,
  input  logic [W-1:0]  mem_wdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] level,
  output logic          ovf_err,
  output logic          unf_err
);
  if (!rf_pkg::cfg_has_headroom(DEPTH, BURST, LOW_MARK)) begin : g_bad_cfg
    $error("refill_stream_buf: LOW_MARK + BURST must not exceed DEPTH");
  end

  logic          wr_fire, rd_fire;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [PW-1:0] pending;

  rf_ptr_track #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
    .clk(clk), .rst(rst),
    .wr_try(mem_wvalid), .rd_try(out_ready),
    .wr_fire(wr_fire), .rd_fire(rd_fire),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(level), .ovf(ovf_err), .unf(unf_err)
  );

  rf_ring_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(wr_fire), .waddr(wr_ptr), .wdata(mem_wdata),
    .raddr(rd_ptr), .rdata(out_data)
  );

  rf_refill_ctl #(.DEPTH(DEPTH), .BURST(BURST), .LOW_MARK(LOW_MARK), .CW(CW), .PW(PW)) u_refill (
    .clk(clk), .rst(rst), .level(level), .wr_fire(wr_fire),
    .mem_ack(mem_ack), .mem_req(mem_req), .pending(pending)
  );

  assign out_valid = (level != '0);

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    $past(rst) |-> (level == '0 && !ovf_err && !unf_err)); // R1
endmodule

// File: tb/refill_stream_buf_bench.sv
`timescale 1ns/1ps
module refill_stream_buf_bench;
  localparam int W = 8, DEPTH = 16, BURST = 4, LOW = 8;
  localparam int CW = $clog2(DEPTH + 1);
  // columns: bytes drained first, ack delay, first-word latency, read during burst
  localparam int NV = 7;
  localparam int VEC [0:NV-1][0:3] = '{
    '{0, 0, 0, 0}, '{0, 2, 3, 0}, '{6, 1, 7, 0}, '{2, 4, 12, 1},
    '{0, 0, 5, 0}, '{8, 3, 0, 0}, '{0, 1, 2, 0}};

  logic clk = 0, rst = 1;
  logic mem_ack = 0, mem_wvalid = 0, out_ready = 0;
  logic [W-1:0] mem_wdata = '0;
  logic mem_req, out_valid, ovf_err, unf_err;
  logic [W-1:0] out_data;
  logic [CW-1:0] level;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [7:0] q[$];
  logic [7:0] src = 8'h10;

  always #4 clk = ~clk;

  refill_stream_buf #(.W(W), .DEPTH(DEPTH), .BURST(BURST), .LOW_MARK(LOW)) u_refill_stream_buf (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .level(level), .ovf_err(ovf_err), .unf_err(unf_err));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, check pre-edge outputs, step, check post-edge.
  task automatic cycle(input bit wv, input bit rdy, input bit ack);
    int n;
    bit wf, rf;
    logic [7:0] popped;
    n = q.size();
    mem_wvalid = wv; mem_wdata = src; out_ready = rdy; mem_ack = ack;
    chk(out_valid == (n > 0), "R3", out_valid, n > 0);
    if (rdy && n > 0) chk(out_data == q[0], "R2", out_data, q[0]);
    @(posedge clk); @(negedge clk);
    wf = wv && (n < DEPTH);
    rf = rdy && (n > 0);
    if (rf) popped = q.pop_front();
    if (wf) begin q.push_back(src); src = src + 8'd1; end
    mem_wvalid = 0; out_ready = 0; mem_ack = 0;
    chk(level == q.size(), (wf && rf) ? "R9" : "R3", level, q.size());
    chk(ovf_err == (wv && n == DEPTH), "R7", ovf_err, wv && n == DEPTH);
    chk(unf_err == (rdy && n == 0), "R8", unf_err, rdy && n == 0);
  endtask

  task automatic serve(input int ack_wait, input int lat, input bit rd);
    int guard = 0;
    while (!mem_req && guard < 60) begin cycle(0, 0, 0); guard++; end
    chk(mem_req == 1, "R4", mem_req, 1);
    for (int i = 0; i < ack_wait; i++) begin
      cycle(0, 0, 0);
      chk(mem_req == 1, "R5", mem_req, 1);
    end
    cycle(0, 0, 1);
    chk(mem_req == 0, "R5", mem_req, 0);
    for (int i = 0; i < lat; i++) begin
      cycle(0, 0, 0);
      chk(mem_req == 0, "R4", mem_req, 0);
    end
    for (int i = 0; i < BURST; i++) begin
      cycle(1, rd, 0);
      chk(mem_req == 0, "R4", mem_req, 0);
    end
    cycle(0, 0, 0);
    if (q.size() < LOW) chk(mem_req == 1, "R6", mem_req, 1);
    else                chk(mem_req == 0, "R4", mem_req, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(level == 0 && !out_valid && !mem_req && !ovf_err && !unf_err, "R1",
        {level, out_valid, mem_req, ovf_err, unf_err}, 0);
    rst = 0;
    @(posedge clk); @(negedge clk);
    chk(mem_req == 1, "R1", mem_req, 1);

    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < VEC[v][0]; k++) cycle(0, 1, 0);
      serve(VEC[v][1], VEC[v][2], VEC[v][3] != 0);
    end

    // At the mark: no request (R4)
    for (int i = 0; i < 3; i++) begin
      cycle(0, 0, 0);
      chk(mem_req == 0, "R4", mem_req, 0);
    end
    // Fill to DEPTH with unrequested words, then overflow (R7)
    while (q.size() < DEPTH) cycle(1, 0, 0);
    chk(level == DEPTH, "R3", level, DEPTH);
    cycle(1, 0, 0);
    chk(level == DEPTH, "R7", level, DEPTH);
    cycle(1, 1, 0);
    chk(level == DEPTH - 1, "R7", level, DEPTH - 1);
    // Drain all, then read at empty (R8)
    while (q.size() > 0) cycle(0, 1, 0);
    cycle(0, 1, 0);
    chk(level == 0 && !out_valid, "R8", level, 0);
    cycle(0, 1, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule